// File: doc/BRIEF.md
# Byte-Order-Selectable Width Down-Converter

This block takes 64-bit words on a valid/ready write port and delivers them as a stream of 8-bit bytes on a valid/ready read port. Words wait in a small queue of wide entries; each word is drained by eight byte handshakes, always starting at the lowest byte lane of the stored word.

A static two-bit mode input picks a byte-lane rearrangement that is applied on the write path before a word is stored. The four settings turn little-endian packed data into big-endian order for element sizes of one, two, four or eight bytes. The rearrangement is plain wiring and costs no cycle. Each word is stored already rearranged, so it keeps the mode that was present when it was written.

The block is used where a wide producer feeds a byte-wide consumer that expects a particular element byte order. The mode is meant to be changed only between words.

Top module: `byte_order_downconv`

## Requirements
- R1: With mode 00 (1-byte elements), one written word leaves as eight bytes in the order of bits [7:0], [15:8], up to [63:56].
- R2: With mode 01 (2-byte elements), the byte order is b1 b0 b3 b2 b5 b4 b7 b6, where bN is bits [8N+7:8N] of the written word.
- R3: With mode 10 (4-byte elements), the byte order is b3 b2 b1 b0 b7 b6 b5 b4.
- R4: With mode 11 (8-byte elements), the byte order is b7 b6 b5 b4 b3 b2 b1 b0.
- R5: The mode is sampled in the cycle a word is accepted; changing it later does not alter the order of bytes from words already stored.
- R6: The rearrangement adds no latency: in the cycle after a word is accepted into an empty block, outValid is high and outData shows that word's first byte.
- R7: inReady is low exactly when DEPTH (default 4) words are stored; a word offered while inReady is low is dropped and never appears on the output.
- R8: outValid is low when no word is stored; while outValid is high and outReady is low, outValid and outData hold.
- R9: A word write and the acceptance of the eighth byte of the oldest word in the same cycle are both honoured.
- R10: A synchronous reset (rst high) empties the block: after it, outValid is low and inReady is high, and a word that was stored is gone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Byte-lane arrangement: 00 none, 01 pair swap, 10 quad reverse, 11 full reverse |
| inValid | input | 1 | Write word offered |
| inReady | output | 1 | Room for a word |
| inData | input | 64 | Write word |
| outValid | output | 1 | A byte is presented |
| outReady | input | 1 | Consumer takes the byte |
| outData | output | 8 | Current byte |

## Verification
The bench drains one word in each of the four modes against orders written out per mode, so a design that swapped the wrong lane pairs or reversed across the wrong group size would deliver a byte in the wrong position. It changes the mode while words are queued, which catches a design that applies the rearrangement at the read side. It fills the queue and offers an extra word, catching an overflow that overwrites the oldest entry, and it stalls the consumer to catch a byte counter that advances without a handshake. It also writes a word in the same cycle that the last byte of another leaves, where a design that let one event win would lose or duplicate a word, and it resets with a word stored.

// File: rtl/bod_pkg.sv
package bod_pkg;

  typedef enum logic [1:0] {
    SWZ_NONE = 2'b00,
    SWZ_PAIR = 2'b01,
    SWZ_QUAD = 2'b10,
    SWZ_FULL = 2'b11
  } swz_mode_e;

  typedef struct packed {
    logic      wrEn;
    swz_mode_e wrMode;
  } dp_strobe_t;

endpackage

// File: rtl/bod_swizzle.sv
module bod_swizzle
  import bod_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  swz_mode_e         modeSel,
  input  logic [WORD_W-1:0] rawWord,
  output logic [WORD_W-1:0] swzWord
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int SRC_PAIR = (i / 2) * 2 + (1 - (i % 2));
    localparam int SRC_QUAD = (i / 4) * 4 + (3 - (i % 4));
    localparam int SRC_FULL = LANES - 1 - i;

    always_comb begin
      unique case (modeSel)
        SWZ_NONE: swzWord[i*BYTE_W +: BYTE_W] = rawWord[i*BYTE_W +: BYTE_W];
        SWZ_PAIR: swzWord[i*BYTE_W +: BYTE_W] = rawWord[SRC_PAIR*BYTE_W +: BYTE_W];
        SWZ_QUAD: swzWord[i*BYTE_W +: BYTE_W] = rawWord[SRC_QUAD*BYTE_W +: BYTE_W];
        default:  swzWord[i*BYTE_W +: BYTE_W] = rawWord[SRC_FULL*BYTE_W +: BYTE_W];
      endcase
    end
  end

endmodule

// File: rtl/bod_ctrl.sv
module bod_ctrl
  import bod_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LANES = 8,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output dp_strobe_t        strobe,
  output logic [PTR_W-1:0]  wrIdx,
  output logic [PTR_W-1:0]  rdIdx,
  output logic [LANE_W-1:0] laneIdx
);

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  wordCnt;
  logic [LANE_W-1:0] byteCnt;
  logic              pushWord, byteTaken, popWord;

  assign inReady   = (wordCnt != CNT_W'(DEPTH));
  assign outValid  = (wordCnt != '0);
  assign pushWord  = inValid && inReady;
  assign byteTaken = outValid && outReady;
  assign popWord   = byteTaken && (byteCnt == LANE_W'(LANES - 1));

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wordCnt <= '0;
      byteCnt <= '0;
    end else begin
      if (pushWord) wrPtr <= nextPtr(wrPtr);
      if (popWord)  rdPtr <= nextPtr(rdPtr);
      if (byteTaken) begin
        byteCnt <= popWord ? '0 : byteCnt + 1'b1;
      end
      unique case ({pushWord, popWord})
        2'b10:   wordCnt <= wordCnt + 1'b1;
        2'b01:   wordCnt <= wordCnt - 1'b1;
        default: wordCnt <= wordCnt;
      endcase
    end
  end

  assign strobe.wrEn   = pushWord;
  assign strobe.wrMode = swz_mode_e'(mode);
  assign wrIdx         = wrPtr;
  assign rdIdx         = rdPtr;
  assign laneIdx       = byteCnt;

endmodule

// File: rtl/bod_datapath.sv
module bod_datapath
  import bod_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  dp_strobe_t        strobe,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [LANE_W-1:0] laneIdx,
  input  logic [WORD_W-1:0] inData,
  output logic [BYTE_W-1:0] outData
);

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] swzWord;
  logic [WORD_W-1:0] headWord;

  bod_swizzle #(
    .LANES (LANES),
    .BYTE_W(BYTE_W)
  ) swz_i (
    .modeSel(strobe.wrMode),
    .rawWord(inData),
    .swzWord(swzWord)
  );

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrIdx] <= swzWord;
  end

  assign headWord = store[rdIdx];
  assign outData  = headWord[laneIdx*BYTE_W +: BYTE_W];

endmodule

// File: rtl/byte_order_downconv.sv
module byte_order_downconv
  import bod_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outData
);

  dp_strobe_t        strobe;
  logic [PTR_W-1:0]  wrIdx, rdIdx;
  logic [LANE_W-1:0] laneIdx;

  bod_ctrl #(
    .DEPTH(DEPTH),
    .LANES(LANES)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .rdIdx   (rdIdx),
    .laneIdx (laneIdx)
  );

  bod_datapath #(
    .DEPTH (DEPTH),
    .LANES (LANES),
    .BYTE_W(BYTE_W)
  ) dp_i (
    .clk    (clk),
    .strobe (strobe),
    .wrIdx  (wrIdx),
    .rdIdx  (rdIdx),
    .laneIdx(laneIdx),
    .inData (inData),
    .outData(outData)
  );

endmodule

// File: rtl/bod_checker.sv
module bod_checker #(
  parameter int DEPTH  = 4,
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [BYTE_W-1:0] outData
);

  logic [CNT_W-1:0]  ckCnt;
  logic [LANE_W-1:0] ckByte;
  logic              ckPush, ckPop;

  assign ckPush = inValid && inReady;
  assign ckPop  = outValid && outReady && (ckByte == LANE_W'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ckCnt  <= '0;
      ckByte <= '0;
    end else begin
      if (outValid && outReady) ckByte <= ckPop ? '0 : ckByte + 1'b1;
      if (ckPush && !ckPop) ckCnt <= ckCnt + 1'b1;
      else if (!ckPush && ckPop) ckCnt <= ckCnt - 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ckCnt == CNT_W'(DEPTH)) |-> !inReady); // R7

  AST_ROOM_READY: assert property (@(posedge clk) disable iff (rst)
    (ckCnt < CNT_W'(DEPTH)) |-> inReady); // R7

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ckCnt == '0) |-> !outValid); // R8

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R8

  AST_BOTH_KEPT: assert property (@(posedge clk) disable iff (rst)
    (ckPush && ckPop && ckCnt == CNT_W'(1)) |=> outValid); // R9

endmodule

bind byte_order_downconv bod_checker #(
  .DEPTH (DEPTH),
  .LANES (LANES),
  .BYTE_W(BYTE_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData)
);

// File: tb/byte_order_downconv_tb_top.sv
`timescale 1ns/1ps
module byte_order_downconv_tb_top;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outData;

  int applied = 0;
  int miscompares = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;

  byte_order_downconv #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int srcLane(input int m, input int k);
    case (m)
      0: return k;
      1: return k ^ 1;
      2: return (k < 4) ? (3 - k) : (11 - k);
      default: return 7 - k;
    endcase
  endfunction

  function automatic logic [7:0] expByte(input logic [63:0] d, input int m, input int k);
    return d[srcLane(m, k)*8 +: 8];
  endfunction

  // All tasks start and end at a falling edge.
  task automatic writeWord(input logic [63:0] d, input logic [1:0] m);
    inValid = 1'b1; inData = d; mode = m;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic readWord(input logic [63:0] d, input int m, input string tag);
    for (int k = 0; k < 8; k++) begin
      outReady = 1'b1;
      chk(outValid === 1'b1 && outData === expByte(d, m, k), tag,
          {55'd0, outValid, outData}, {56'd1, expByte(d, m, k)});
      @(negedge clk);
    end
    outReady = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk(outValid === 1'b0, "R10 outValid after reset", outValid, 0);
    chk(inReady === 1'b1, "R10 inReady after reset", inReady, 1);
  endtask

  task automatic t_modes();
    logic [63:0] w;
    for (int m = 0; m < 4; m++) begin
      w = 64'h8877_6655_4433_2211 + 64'(m) * 64'h0101_0101_0101_0101;
      writeWord(w, 2'(m));
      chk(outValid === 1'b1 && outData === expByte(w, m, 0), "R6 first byte next cycle",
          {55'd0, outValid, outData}, {56'd1, expByte(w, m, 0)});
      case (m)
        0: readWord(w, m, "R1 mode 00 order");
        1: readWord(w, m, "R2 mode 01 order");
        2: readWord(w, m, "R3 mode 10 order");
        default: readWord(w, m, "R4 mode 11 order");
      endcase
      chk(outValid === 1'b0, "R8 empty after drain", outValid, 0);
    end
  endtask

  task automatic t_modeLatch();
    writeWord(64'h0F0E_0D0C_0B0A_0908, 2'b11);
    writeWord(64'hA7A6_A5A4_A3A2_A1A0, 2'b01);
    mode = 2'b00;
    @(negedge clk);
    readWord(64'h0F0E_0D0C_0B0A_0908, 3, "R5 stored full reverse kept");
    mode = 2'b10;
    readWord(64'hA7A6_A5A4_A3A2_A1A0, 1, "R5 stored pair swap kept");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      chk(inReady === 1'b1, "R7 ready with room", inReady, 1);
      writeWord(64'h1000_0000_0000_0000 * 64'(i + 1) + 64'(i), 2'b00);
    end
    chk(inReady === 1'b0, "R7 not ready when full", inReady, 0);
    writeWord(64'hDEAD_BEEF_DEAD_BEEF, 2'b00);
    for (int i = 0; i < DEPTH; i++)
      readWord(64'h1000_0000_0000_0000 * 64'(i + 1) + 64'(i), 0, "R7 queued word intact");
    chk(outValid === 1'b0, "R7 dropped word absent", outValid, 0);
  endtask

  task automatic t_stall();
    logic [7:0] first;
    writeWord(64'h5566_7788_99AA_BBCC, 2'b10);
    first = outData;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(outValid === 1'b1 && outData === first, "R8 hold under stall",
          {55'd0, outValid, outData}, {56'd1, first});
    end
    readWord(64'h5566_7788_99AA_BBCC, 2, "R8 order after stall");
  endtask

  task automatic t_simul();
    logic [63:0] a, b;
    a = 64'h0102_0304_0506_0708;
    b = 64'hF1F2_F3F4_F5F6_F7F8;
    writeWord(a, 2'b00);
    for (int k = 0; k < 7; k++) begin
      outReady = 1'b1;
      chk(outData === expByte(a, 0, k), "R9 leading bytes", outData, expByte(a, 0, k));
      @(negedge clk);
    end
    outReady = 1'b1;
    inValid = 1'b1; inData = b; mode = 2'b11;
    chk(outData === expByte(a, 0, 7), "R9 last byte", outData, expByte(a, 0, 7));
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b0;
    chk(outValid === 1'b1, "R9 new word kept", outValid, 1);
    readWord(b, 3, "R9 new word order");
    chk(outValid === 1'b0, "R9 old word not repeated", outValid, 0);
  endtask

  task automatic t_resetStored();
    writeWord(64'h1234_5678_9ABC_DEF0, 2'b00);
    doReset();
    chk(outValid === 1'b0, "R10 stored word cleared", outValid, 0);
    chk(inReady === 1'b1, "R10 ready after clear", inReady, 1);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_modes();
    t_modeLatch();
    t_full();
    t_stall();
    t_simul();
    t_resetStored();
    finishRun();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    applied++;
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

endmodule